// File: doc/BRIEF.md
# Single-Context Platform Interrupt Controller

This block gathers up to `NUM_SRC` level-sensitive interrupt lines and presents them to one processor target through a small register bus. Software gives each source a priority and an enable bit, and sets a threshold for the target. A source can interrupt only when it is pending, enabled, and its priority is strictly above that threshold. The block drives one request line whenever such a source exists.

Servicing is a two-step handshake. Reading the claim register returns the ID of the best qualifying source and takes that source out of contention. Writing the same ID back to the claim register ends the service, and the source may then be forwarded again. ID 0 means "nothing to claim" and never interrupts.

Each source is tracked by a small state machine with three states. In `GW_IDLE` the source is quiet. The transition idle-to-pending happens when the level input is high at a clock edge. In `GW_PEND` the source is latched as pending. The transition pending-to-service happens when a claim read selects this source. In `GW_SVC` the source is hidden from arbitration. The transition service-to-idle happens when its own ID is written as a complete.

Top module: `plic_context`

## Requirements
- R1: After reset `irq_o` is low, every priority and enable bit is zero, the threshold is zero, and a claim read returns 0.
- R2: The priority of source k sits at byte address 4·k (k = 0…NUM_SRC) and is PRIO_W bits wide; upper read bits are zero. The priority of ID 0 always reads 0 and ignores writes. Any other address in the 0x000–0x0FF window that has no source reads 0.
- R3: Enable word w sits at byte address 0x100 + 4·w. Source k uses bit k mod 32 of word k div 32. Bit 0 of word 0 (ID 0) always reads 0, and bits with no source read 0.
- R4: The threshold sits at 0x200 and is PRIO_W bits wide. A source qualifies only if its priority is strictly greater than the threshold, so a threshold of all ones masks every source.
- R5: `irq_o` is high in the same cycle that any source is pending, enabled and above threshold, and low otherwise.
- R6: A read of 0x204 (claim) returns, on `bus_rdata_o` in the cycle after the read strobe, the qualifying source with the highest priority. When priorities tie, the lowest ID wins. The read returns 0 when no source qualifies. All other reads also return data one cycle after the strobe.
- R7: A claimed source leaves the pending state and is not pending again while in service, whatever its level does.
- R8: Writing the ID of an in-service source to 0x204 completes it. If its level is high, it is pending again one edge later.
- R9: A complete write whose value is not the ID of an in-service source changes nothing.
- R10: Pending is latched: once a source is pending, a drop of its level does not remove the pending state before it is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC (index NUM_SRC:1) | Level interrupt inputs; bit k is source k |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Interrupt request to the target |

## Verification
The hardest situation to reach is a source that is in service while its level stays high, together with other sources of equal priority waiting. Only in this situation can the hiding, the lowest-ID tie break and a mismatched or stale complete all be observed at the same time. Directed sequences build this situation on purpose: two equal-priority sources are raised, claimed one after the other, and completed with a wrong ID and then the right one. Seeded random traffic then mixes level flips, priority and threshold writes, claims and completes with random IDs (including out-of-range ones), so that many sources pass through service with their levels still asserted.

// File: rtl/plic_pkg.sv
package plic_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [3:0]        WIN_PRIO  = 4'h0;
    localparam logic [3:0]        WIN_EN    = 4'h1;
    localparam logic [ADDR_W-1:0] ADDR_THR  = 12'h200;
    localparam logic [ADDR_W-1:0] ADDR_CLM  = 12'h204;

    typedef enum logic [1:0] {
        GW_IDLE = 2'd0,
        GW_PEND = 2'd1,
        GW_SVC  = 2'd2
    } gw_state_t;
endpackage

// File: rtl/plic_gateway.sv
module plic_gateway
    import plic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pending_o,
    output logic in_service_o
);
    gw_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GW_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_IDLE: if (level_i)    state_d = GW_PEND;
            GW_PEND: if (claim_i)    state_d = GW_SVC;
            GW_SVC:  if (complete_i) state_d = GW_IDLE;
            default:                 state_d = GW_IDLE;
        endcase
    end

    always_comb begin
        pending_o    = (state_q == GW_PEND);
        in_service_o = (state_q == GW_SVC);
    end
endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter #(
    parameter int NUM_SRC = 31,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 5
) (
    input  logic [NUM_SRC:0]              cand_i,
    input  logic [(NUM_SRC+1)*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]             thr_i,
    output logic [ID_W-1:0]               win_id_o
);
    logic [PRIO_W-1:0] best_p;

    always_comb begin
        best_p   = '0;
        win_id_o = '0;
        for (int k = 1; k <= NUM_SRC; k++) begin
            if (cand_i[k] && (prio_i[k*PRIO_W +: PRIO_W] > thr_i)
                          && (prio_i[k*PRIO_W +: PRIO_W] > best_p)) begin
                best_p   = prio_i[k*PRIO_W +: PRIO_W];
                win_id_o = ID_W'(k);
            end
        end
    end
endmodule

// File: rtl/plic_context.sv
module plic_context
    import plic_pkg::*;
#(
    parameter int NUM_SRC = 31,
    parameter int PRIO_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC:1]  src_i,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic [11:0]       bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o
);
    localparam int ID_W    = $clog2(NUM_SRC + 1);
    localparam int N_WORDS = (NUM_SRC + 32) / 32;

    logic [(NUM_SRC+1)*PRIO_W-1:0] prio_q;
    logic [NUM_SRC:0]              en_q;
    logic [PRIO_W-1:0]             thr_q;
    logic [NUM_SRC:0]              pend_vec;
    logic [NUM_SRC:0]              svc_vec;
    logic [ID_W-1:0]               win_id;
    logic [DATA_W-1:0]             rd_mux;
    logic [DATA_W-1:0]             rdata_q;

    logic [5:0] word_idx;
    logic       sel_prio, sel_en, sel_thr, sel_clm;
    logic       claim_fire, cmpl_fire;

    assign word_idx   = bus_addr_i[7:2];
    assign sel_prio   = (bus_addr_i[11:8] == WIN_PRIO);
    assign sel_en     = (bus_addr_i[11:8] == WIN_EN) && (int'(word_idx) < N_WORDS);
    assign sel_thr    = (bus_addr_i == ADDR_THR);
    assign sel_clm    = (bus_addr_i == ADDR_CLM);
    assign claim_fire = bus_rd_i && sel_clm;
    assign cmpl_fire  = bus_wr_i && sel_clm;

    // Per-source gateways; ID 0 has none.
    assign pend_vec[0] = 1'b0;
    assign svc_vec[0]  = 1'b0;
    for (genvar k = 1; k <= NUM_SRC; k++) begin : g_src
        logic claim_hit, cmpl_hit;
        assign claim_hit = claim_fire && (win_id == ID_W'(k));
        assign cmpl_hit  = cmpl_fire && (bus_wdata_i == DATA_W'(k));
        plic_gateway u_gw (
            .clk          (clk),
            .rst_n        (rst_n),
            .level_i      (src_i[k]),
            .claim_i      (claim_hit),
            .complete_i   (cmpl_hit),
            .pending_o    (pend_vec[k]),
            .in_service_o (svc_vec[k])
        );
    end

    plic_arbiter #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .ID_W    (ID_W)
    ) u_arb (
        .cand_i   (pend_vec & en_q),
        .prio_i   (prio_q),
        .thr_i    (thr_q),
        .win_id_o (win_id)
    );

    assign irq_o = (win_id != '0);

    // Configuration registers; entries of ID 0 are never written.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (bus_wr_i) begin
            if (sel_prio) begin
                for (int k = 1; k <= NUM_SRC; k++)
                    if (word_idx == 6'(k)) prio_q[k*PRIO_W +: PRIO_W] <= bus_wdata_i[PRIO_W-1:0];
            end
            if (sel_en) begin
                for (int k = 1; k <= NUM_SRC; k++)
                    if (word_idx == 6'(k / 32)) en_q[k] <= bus_wdata_i[k % 32];
            end
            if (sel_thr) thr_q <= bus_wdata_i[PRIO_W-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (sel_prio) begin
            for (int k = 1; k <= NUM_SRC; k++)
                if (word_idx == 6'(k)) rd_mux[PRIO_W-1:0] = prio_q[k*PRIO_W +: PRIO_W];
        end else if (sel_en) begin
            for (int k = 1; k <= NUM_SRC; k++)
                if (word_idx == 6'(k / 32)) rd_mux[k % 32] = en_q[k];
        end else if (sel_thr) begin
            rd_mux[PRIO_W-1:0] = thr_q;
        end else if (sel_clm) begin
            rd_mux[ID_W-1:0] = win_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rdata_q <= '0;
        else if (bus_rd_i) rdata_q <= rd_mux;
    end

    assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/plic_checker.sv
module plic_checker #(
    parameter int NUM_SRC = 31,
    parameter int PRIO_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd_i,
    input logic              bus_wr_i,
    input logic [11:0]       bus_addr_i,
    input logic [31:0]       bus_rdata_o,
    input logic              irq_o,
    input logic [PRIO_W-1:0] thr_q,
    input logic [NUM_SRC:0]  en_q,
    input logic [NUM_SRC:0]  pend_vec,
    input logic [NUM_SRC:0]  svc_vec
);
    p_full_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_q == '1) |-> !irq_o);

    p_no_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_o);

    p_claim_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == 12'h204 && !irq_o) |=> (bus_rdata_o == 32'd0));

    p_claim_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == 12'h204 && irq_o) |=>
        (bus_rdata_o != 32'd0 && bus_rdata_o <= 32'(NUM_SRC)));

    p_hidden_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_vec & svc_vec) == '0));

    p_svc_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_i && bus_addr_i == 12'h204) |=> (($past(svc_vec) & ~svc_vec) == '0));
endmodule

bind plic_context plic_checker #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd_i    (bus_rd_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .thr_q       (thr_q),
    .en_q        (en_q),
    .pend_vec    (pend_vec),
    .svc_vec     (svc_vec)
);

// File: tb/tb_plic_context.sv
module tb_plic_context;
    localparam int N  = 31;
    localparam int PW = 3;
    localparam int unsigned PMASK = (1 << PW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N:1]  src = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #10 clk = ~clk;

    plic_context #(.NUM_SRC(N), .PRIO_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .bus_rd_i(bus_rd), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    int unsigned m_prio [0:N];
    bit          m_en   [0:N];
    int unsigned m_thr;
    int          m_st   [0:N];   // 0 idle, 1 pending, 2 in service
    bit          lvl    [0:N];

    task automatic chk(input string req, input string what, input int unsigned act, input int unsigned exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int model_best();
        int unsigned bp = 0;
        int id = 0;
        for (int k = 1; k <= N; k++)
            if (m_st[k] == 1 && m_en[k] && m_prio[k] > m_thr && m_prio[k] > bp) begin
                bp = m_prio[k];
                id = k;
            end
        return id;
    endfunction

    function automatic int unsigned model_read(input int unsigned a, output string req);
        int unsigned v = 0;
        req = "R2";
        if (a < 32'h100) begin
            if ((a >> 2) >= 1 && (a >> 2) <= N) v = m_prio[a >> 2];
        end else if (a < 32'h200) begin
            req = "R3";
            for (int k = 1; k <= N; k++)
                if (k / 32 == int'((a - 32'h100) >> 2)) v[k % 32] = m_en[k];
        end else if (a == 32'h200) begin
            req = "R4"; v = m_thr;
        end else if (a == 32'h204) begin
            req = "R6"; v = model_best();
        end else begin
            req = "R2";
        end
        return v;
    endfunction

    task automatic cyc(input bit rd, input bit wr, input int unsigned a, input int unsigned wd, input string tag);
        int unsigned exp_rd = 0;
        int cid = 0;
        string req;
        for (int k = 1; k <= N; k++) src[k] = lvl[k];
        bus_rd = rd; bus_wr = wr; bus_addr = a[11:0]; bus_wdata = wd;
        if (rd) exp_rd = model_read(a & 32'hFFF, req);
        if (rd && (a & 32'hFFF) == 32'h204) cid = int'(exp_rd);
        @(posedge clk);
        for (int k = 1; k <= N; k++) begin
            case (m_st[k])
                0: if (lvl[k]) m_st[k] = 1;
                1: if (cid == k) m_st[k] = 2;
                default: if (wr && (a & 32'hFFF) == 32'h204 && wd == k) m_st[k] = 0;
            endcase
        end
        if (wr) begin
            int unsigned aa = a & 32'hFFF;
            if (aa < 32'h100) begin
                if ((aa >> 2) >= 1 && (aa >> 2) <= N) m_prio[aa >> 2] = wd & PMASK;
            end else if (aa < 32'h200) begin
                for (int k = 1; k <= N; k++)
                    if (k / 32 == int'((aa - 32'h100) >> 2)) m_en[k] = wd[k % 32];
            end else if (aa == 32'h200) begin
                m_thr = wd & PMASK;
            end
        end
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        chk("R5", {tag, " irq"}, int'(irq), (model_best() != 0) ? 1 : 0);
        if (rd) chk(req, {tag, " rdata"}, bus_rdata, exp_rd);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int k = 0; k <= N; k++) begin
            m_prio[k] = 0; m_en[k] = 0; m_st[k] = 0; lvl[k] = 0;
        end
        m_thr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1", "irq after reset", int'(irq), 0);
        cyc(1, 0, 32'h204, 0, "R1 claim");
        cyc(1, 0, 32'h004, 0, "R1 prio");
        cyc(1, 0, 32'h100, 0, "R1 enable");
        cyc(1, 0, 32'h200, 0, "R1 thr");

        // R2 priority layout and ID 0
        cyc(0, 1, 32'h000, 7, "R2 id0 write");
        cyc(1, 0, 32'h000, 0, "R2 id0 read");
        cyc(0, 1, 32'h00C, 32'hFF, "R2 width");
        cyc(1, 0, 32'h00C, 0, "R2 width read");
        cyc(1, 0, 32'h0FC, 0, "R2 no source");

        // R3 enable layout
        cyc(0, 1, 32'h100, 32'hFFFF_FFFF, "R3 enable all");
        cyc(1, 0, 32'h100, 0, "R3 bit0 zero");

        // R6 tie break, R7 hiding, R9 wrong complete, R8 completion, R10 latch
        cyc(0, 1, 32'h014, 4, "R6 prio5");
        cyc(0, 1, 32'h024, 4, "R6 prio9");
        lvl[9] = 1; lvl[5] = 1;
        cyc(0, 0, 0, 0, "R5 raise");
        lvl[9] = 0;
        cyc(0, 0, 0, 0, "R10 level drop");
        cyc(1, 0, 32'h204, 0, "R6 tie lowest");
        cyc(1, 0, 32'h204, 0, "R10 latched 9");
        cyc(1, 0, 32'h204, 0, "R7 hidden");
        cyc(0, 1, 32'h204, 12, "R9 wrong id");
        cyc(0, 1, 32'h204, 0, "R9 id zero");
        cyc(1, 0, 32'h204, 0, "R9 still hidden");
        cyc(0, 1, 32'h204, 5, "R8 complete");
        cyc(0, 0, 0, 0, "R8 repend");
        cyc(1, 0, 32'h204, 0, "R8 reclaim");
        cyc(0, 1, 32'h204, 9, "R8 complete 9");

        // R4 threshold strictness and full mask
        cyc(0, 1, 32'h204, 5, "R8 complete 5");
        cyc(0, 1, 32'h200, 4, "R4 equal");
        cyc(0, 1, 32'h200, 3, "R4 below");
        cyc(0, 1, 32'h200, 7, "R4 all ones");
        cyc(1, 0, 32'h204, 0, "R4 masked claim");
        cyc(0, 1, 32'h200, 0, "R4 clear");

        // seeded random traffic
        for (int i = 0; i < 4000; i++) begin
            int op = int'($urandom % 10);
            if ($urandom % 3 == 0) begin
                int s = 1 + int'($urandom % N);
                lvl[s] = ~lvl[s];
            end
            case (op)
                0: cyc(0, 1, (1 + $urandom % N) * 4, $urandom, "R2 rnd prio");
                1: cyc(0, 1, 32'h100 + ($urandom % 2) * 4, $urandom, "R3 rnd enable");
                2: cyc(0, 1, 32'h200, ($urandom % 5 == 0) ? 7 : $urandom % 3, "R4 rnd thr");
                3, 4, 5: cyc(1, 0, 32'h204, 0, "R6 rnd claim");
                6, 7: cyc(0, 1, 32'h204, $urandom % (N + 3), "R8 rnd complete");
                8: cyc(1, 0, ($urandom % 40) * 4 + (($urandom % 2) ? 32'h100 : 0), 0, "R2 rnd read");
                default: cyc(0, 0, 0, 0, "R5 rnd idle");
            endcase
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule